// File: doc/BRIEF.md
# Configurable-Sense External Interrupt Controller

This block collects up to 32 external interrupt lines and merges them into a single interrupt request for a processor. Each line is set up by software on its own as edge-sensitive or level-sensitive. An edge line fires on a rising or a falling edge. A level line fires while it is high or while it is low. Every line has a sticky status bit and an enable bit. The merged request is raised whenever any enabled line has status pending.

Software reaches the block through a plain register port: a 6-bit byte address, a write strobe, 32-bit write data and combinational read data. Enable bits are changed through separate set and clear write locations, so software never has to do a read-modify-write. Pending status is cleared by writing ones to it.

Line 0 can also drive a separate non-maskable output. A test mode replaces the pins with software-written values so that the detection logic can be exercised without external stimulus. The number of implemented lines is a parameter. Software finds it by writing all ones to the sense-type register and reading the value back.

Top module: `xint_ctrl`

## Requirements
- R1: After reset the enable, status, sense-type, edge-direction, level-polarity, NMI and test registers all read zero, and `irq_out` and `nmi_out` are low.
- R2: A write to offset 0x00 sets every enable bit that is 1 in the data. A write to offset 0x04 clears every enable bit that is 1 in the data. Bits that are 0 in either write leave the enable unchanged. The enables read back at offset 0x08.
- R3: The sense-type register at offset 0x14 stores only bits below NUM_LINES. Writing all ones and reading back returns a value with exactly NUM_LINES low bits set.
- R4: In reset configuration (sense-type bit 0, edge-direction bit 0), a line sets its status bit on a falling edge. A pin change is first visible in status, read at offset 0x0C, after the third rising clock edge. A rising edge sets nothing.
- R5: With sense-type bit 0 and edge-direction bit 1 (offset 0x18), the line sets its status on a rising edge and ignores falling edges.
- R6: With sense-type bit 1, the line is level-sensitive. Level-polarity bit 1 (offset 0x1C) means active-high and bit 0 means active-low. Status is set on every cycle the active level is present, so a clear has no lasting effect until the level goes away.
- R7: Writing 1s to offset 0x10 clears those status bits, and status bits never fall otherwise. A detection and a clear of the same line on the same edge leave the status bit set.
- R8: `irq_out` is high exactly when some line has both status and enable set. Status still latches while a line is disabled.
- R9: Offset 0x24 bit 0 is the NMI enable. While it is 1, `nmi_out` equals the status of line 0 whatever the enable of line 0. While it is 0, `nmi_out` is low.
- R10: Offset 0x20 bit 31 is the test enable. While it is 1, the data of the last write to offset 0x00 replaces `line_in` as the line source, and pin changes are ignored.

Port order in the table below follows the port list of the top module.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | NUM_LINES | Asynchronous external interrupt lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register byte address |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data (combinational) |
| irq_out | output | 1 | Merged interrupt request |
| nmi_out | output | 1 | Non-maskable request from line 0 |

## Verification
A wrong enable or status bit appears at `irq_out` in the same cycle. It also appears on a read of offset 0x08 or 0x0C with no latency. A wrong sense decode or synchroniser depth shows as a status bit that sets one cycle early or late after a pin change, or that never sets. The bench checks this by comparing each clock against a model that counts the three-edge latency. A mishandled clear-versus-detect collision leaves the status bit low on the cycle after the collision edge, and the same-cycle comparison flags it.

// File: rtl/xint_pkg.sv
package xint_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    typedef enum logic [ADDR_W-1:0] {
        OFS_EN_SET   = 6'h00,
        OFS_EN_CLR   = 6'h04,
        OFS_EN_VIEW  = 6'h08,
        OFS_STAT     = 6'h0C,
        OFS_STAT_CLR = 6'h10,
        OFS_SENSE    = 6'h14,
        OFS_RISE_SEL = 6'h18,
        OFS_HIGH_SEL = 6'h1C,
        OFS_TEST     = 6'h20,
        OFS_NMI      = 6'h24
    } reg_ofs_e;

    // {sense bit, direction/polarity bit}
    typedef enum logic [1:0] {
        TRIG_FALL = 2'b00,
        TRIG_RISE = 2'b01,
        TRIG_LOW  = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_kind_e;

    localparam int TEST_BIT = 31;
    localparam int NMI_BIT  = 0;
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] raw_in,
    output logic [NUM_LINES-1:0] cur,
    output logic [NUM_LINES-1:0] prev
);
    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_line
            logic meta_q, stab_q, old_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    stab_q <= 1'b0;
                    old_q  <= 1'b0;
                end else begin
                    meta_q <= raw_in[g];
                    stab_q <= meta_q;
                    old_q  <= stab_q;
                end
            end
            assign cur[g]  = stab_q;
            assign prev[g] = old_q;
        end
    endgenerate
endmodule

// File: rtl/xint_detect.sv
module xint_detect
    import xint_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic [NUM_LINES-1:0] cur,
    input  logic [NUM_LINES-1:0] prev,
    input  logic [NUM_LINES-1:0] sense_q,
    input  logic [NUM_LINES-1:0] rise_sel_q,
    input  logic [NUM_LINES-1:0] high_sel_q,
    output logic [NUM_LINES-1:0] trig
);
    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_line
            trig_kind_e kind;
            logic       hit;
            always_comb begin
                kind = trig_kind_e'({sense_q[g],
                                     sense_q[g] ? high_sel_q[g] : rise_sel_q[g]});
                unique case (kind)
                    TRIG_FALL: hit = ~cur[g] &  prev[g];
                    TRIG_RISE: hit =  cur[g] & ~prev[g];
                    TRIG_LOW:  hit = ~cur[g];
                    TRIG_HIGH: hit =  cur[g];
                    default:   hit = 1'b0;
                endcase
            end
            assign trig[g] = hit;
        end
    endgenerate
endmodule

// File: rtl/xint_regs.sv
module xint_regs
    import xint_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [NUM_LINES-1:0] mask_q,
    output logic [NUM_LINES-1:0] sense_q,
    output logic [NUM_LINES-1:0] rise_sel_q,
    output logic [NUM_LINES-1:0] high_sel_q,
    output logic [NUM_LINES-1:0] test_pat_q,
    output logic                 nmi_en_q,
    output logic                 test_en_q,
    output logic [NUM_LINES-1:0] clr_stb
);
    logic [NUM_LINES-1:0] wd;
    logic                 unused_hi;

    assign wd        = wr_data[NUM_LINES-1:0];
    assign unused_hi = ^wr_data;

    always_comb begin
        clr_stb = '0;
        if (wr_en && addr == OFS_STAT_CLR) clr_stb = wd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q     <= '0;
            sense_q    <= '0;
            rise_sel_q <= '0;
            high_sel_q <= '0;
            test_pat_q <= '0;
            nmi_en_q   <= 1'b0;
            test_en_q  <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                OFS_EN_SET: begin
                    mask_q     <= mask_q | wd;
                    test_pat_q <= wd;
                end
                OFS_EN_CLR:   mask_q     <= mask_q & ~wd;
                OFS_SENSE:    sense_q    <= wd;
                OFS_RISE_SEL: rise_sel_q <= wd;
                OFS_HIGH_SEL: high_sel_q <= wd;
                OFS_TEST:     test_en_q  <= wr_data[TEST_BIT];
                OFS_NMI:      nmi_en_q   <= wr_data[NMI_BIT];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
    import xint_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic                 wr_en,
    input  logic [5:0]           addr,
    input  logic [31:0]          wr_data,
    output logic [31:0]          rd_data,
    output logic                 irq_out,
    output logic                 nmi_out
);
    logic [NUM_LINES-1:0] mask_q, sense_q, rise_sel_q, high_sel_q, test_pat_q;
    logic [NUM_LINES-1:0] clr_stb, src, cur, prev, trig, status_q;
    logic                 nmi_en_q, test_en_q;

    xint_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .mask_q(mask_q), .sense_q(sense_q), .rise_sel_q(rise_sel_q),
        .high_sel_q(high_sel_q), .test_pat_q(test_pat_q), .nmi_en_q(nmi_en_q),
        .test_en_q(test_en_q), .clr_stb(clr_stb)
    );

    assign src = test_en_q ? test_pat_q : line_in;

    xint_sync #(.NUM_LINES(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(src), .cur(cur), .prev(prev)
    );

    xint_detect #(.NUM_LINES(NUM_LINES)) u_detect (
        .cur(cur), .prev(prev), .sense_q(sense_q), .rise_sel_q(rise_sel_q),
        .high_sel_q(high_sel_q), .trig(trig)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_stb) | trig;
    end

    assign irq_out = |(status_q & mask_q);
    assign nmi_out = nmi_en_q & status_q[0];

    always_comb begin
        rd_data = '0;
        case (addr)
            OFS_EN_VIEW:  rd_data[NUM_LINES-1:0] = mask_q;
            OFS_STAT:     rd_data[NUM_LINES-1:0] = status_q;
            OFS_SENSE:    rd_data[NUM_LINES-1:0] = sense_q;
            OFS_RISE_SEL: rd_data[NUM_LINES-1:0] = rise_sel_q;
            OFS_HIGH_SEL: rd_data[NUM_LINES-1:0] = high_sel_q;
            OFS_TEST:     rd_data[TEST_BIT]      = test_en_q;
            OFS_NMI:      rd_data[NMI_BIT]       = nmi_en_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/xint_ctrl_chk.sv
module xint_ctrl_chk
    import xint_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [5:0]           addr,
    input logic [31:0]          wr_data,
    input logic [NUM_LINES-1:0] mask_q,
    input logic [NUM_LINES-1:0] status_q,
    input logic [NUM_LINES-1:0] trig,
    input logic                 nmi_en_q,
    input logic                 irq_out,
    input logic                 nmi_out
);
    a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_EN_SET) |=>
        ((mask_q & $past(wr_data[NUM_LINES-1:0])) == $past(wr_data[NUM_LINES-1:0])));

    a_r2_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_EN_CLR) |=>
        ((mask_q & $past(wr_data[NUM_LINES-1:0])) == '0));

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == OFS_STAT_CLR) |=>
        ((status_q & $past(status_q)) == $past(status_q)));

    a_r7_detect_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|trig) |=> ((status_q & $past(trig)) == $past(trig)));

    a_r8_all_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_out);

    a_r9_nmi_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_en_q |-> !nmi_out);
endmodule

bind xint_ctrl xint_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .mask_q(mask_q), .status_q(status_q), .trig(trig), .nmi_en_q(nmi_en_q),
    .irq_out(irq_out), .nmi_out(nmi_out)
);

// File: tb/xint_ctrl_bench.sv
module xint_ctrl_bench;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  line_in = '1;
    logic          wr_en = 1'b0;
    logic [5:0]    addr = '0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic          irq_out, nmi_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    xint_ctrl #(.NUM_LINES(N)) u_xint_ctrl (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out), .nmi_out(nmi_out)
    );

    // behavioural reference
    bit [N-1:0] m_s1, m_s2, m_p, m_stat, m_mask, m_sense, m_rise, m_high, m_pat;
    bit         m_nmi, m_test;

    function automatic bit [31:0] m_read(input bit [5:0] a);
        bit [31:0] r = 0;
        case (a)
            6'h08: r[N-1:0] = m_mask;
            6'h0C: r[N-1:0] = m_stat;
            6'h14: r[N-1:0] = m_sense;
            6'h18: r[N-1:0] = m_rise;
            6'h1C: r[N-1:0] = m_high;
            6'h20: r[31] = m_test;
            6'h24: r[0] = m_nmi;
            default: r = 0;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        bit [N-1:0] fire, clr, d;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_p = 0; m_stat = 0; m_mask = 0; m_sense = 0;
            m_rise = 0; m_high = 0; m_pat = 0; m_nmi = 0; m_test = 0;
        end else begin
            d = wr_data[N-1:0];
            fire = 0;
            for (int i = 0; i < N; i++) begin
                if (m_sense[i]) fire[i] = m_high[i] ? m_s2[i] : !m_s2[i];
                else if (m_rise[i]) fire[i] = m_s2[i] && !m_p[i];
                else fire[i] = !m_s2[i] && m_p[i];
            end
            clr = (wr_en && addr == 6'h10) ? d : 0;
            m_stat = (m_stat & ~clr) | fire;
            m_p = m_s2;
            m_s2 = m_s1;
            m_s1 = m_test ? m_pat : line_in;
            if (wr_en) begin
                case (addr)
                    6'h00: begin m_mask = m_mask | d; m_pat = d; end
                    6'h04: m_mask = m_mask & ~d;
                    6'h14: m_sense = d;
                    6'h18: m_rise = d;
                    6'h1C: m_high = d;
                    6'h20: m_test = wr_data[31];
                    6'h24: m_nmi = wr_data[0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R8 irq_out", {31'b0, irq_out}, {31'b0, |(m_stat & m_mask)});
            chk("R9 nmi_out", {31'b0, nmi_out}, {31'b0, m_nmi & m_stat[0]});
            chk("R2 rd_data", rd_data, m_read(addr));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        addr = a;
        @(negedge clk); v = rd_data;
        @(posedge clk); #1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog (all requirements) actual=hung expected=done");
        summary();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(4);
        // R1 reset state
        rd(6'h08, v); chk("R1 enable reset", v, 0);
        rd(6'h0C, v); chk("R1 status reset", v, 0);
        rd(6'h14, v); chk("R1 sense reset", v, 0);
        rd(6'h24, v); chk("R1 nmi reset", v, 0);
        rd(6'h20, v); chk("R1 test reset", v, 0);
        chk("R1 irq low", {31'b0, irq_out}, 0);
        // R3 line count discovery
        wr(6'h14, 32'hFFFF_FFFF);
        rd(6'h14, v); chk("R3 sense readback", v, 32'h0000_00FF);
        wr(6'h14, 0);
        // R2 set / clear enables
        wr(6'h00, 32'h05); rd(6'h08, v); chk("R2 set", v, 32'h05);
        wr(6'h00, 32'h02); rd(6'h08, v); chk("R2 set keeps", v, 32'h07);
        wr(6'h04, 32'h04); rd(6'h08, v); chk("R2 clear", v, 32'h03);
        wr(6'h04, 32'h00); rd(6'h08, v); chk("R2 zero clear", v, 32'h03);
        // R4 falling edge with three-edge latency
        line_in[1] = 1'b0;
        idle(2);
        rd(6'h0C, v); chk("R4 not yet", v, 0);
        addr = 6'h0C; @(negedge clk);
        chk("R4 falling set", rd_data, 32'h02);
        chk("R8 irq on", {31'b0, irq_out}, 1);
        idle(1);
        // R7 clear
        wr(6'h10, 32'h02); rd(6'h0C, v); chk("R7 cleared", v, 0);
        // R5 rising
        wr(6'h18, 32'h04);
        line_in[2] = 1'b0; idle(4);
        rd(6'h0C, v); chk("R5 fall ignored", v, 0);
        line_in[2] = 1'b1; idle(4);
        rd(6'h0C, v); chk("R5 rising set", v, 32'h04);
        chk("R8 latched while disabled", {31'b0, irq_out}, 0);
        wr(6'h00, 32'h04);
        chk("R8 irq after enable", {31'b0, irq_out}, 1);
        wr(6'h10, 32'h04);
        // R6 level high on line 3
        wr(6'h1C, 32'h08); wr(6'h14, 32'h08); idle(3);
        rd(6'h0C, v); chk("R6 level high", v, 32'h08);
        wr(6'h10, 32'h08); rd(6'h0C, v); chk("R6 clear while active", v, 32'h08);
        line_in[3] = 1'b0; idle(4);
        wr(6'h10, 32'h08); rd(6'h0C, v); chk("R6 clear after release", v, 0);
        // R6 level low on line 4
        wr(6'h14, 32'h18); idle(3);
        rd(6'h0C, v); chk("R6 low inactive", v, 0);
        line_in[4] = 1'b0; idle(4);
        rd(6'h0C, v); chk("R6 level low", v, 32'h10);
        line_in[4] = 1'b1; idle(4);
        wr(6'h10, 32'h10);
        // R7 detect wins over simultaneous clear
        line_in[5] = 1'b0;
        idle(2);
        wr(6'h10, 32'h20);
        rd(6'h0C, v); chk("R7 detect wins", v, 32'h20);
        wr(6'h10, 32'h20);
        // R9 NMI
        wr(6'h04, 32'h01);
        line_in[0] = 1'b0; idle(4);
        chk("R9 nmi gated off", {31'b0, nmi_out}, 0);
        chk("R8 masked line0", {31'b0, irq_out}, 0);
        wr(6'h24, 32'h1);
        chk("R9 nmi follows", {31'b0, nmi_out}, 1);
        rd(6'h24, v); chk("R9 nmi reg", v, 1);
        wr(6'h10, 32'h01);
        chk("R9 nmi cleared", {31'b0, nmi_out}, 0);
        // R10 test drive
        wr(6'h14, 0); wr(6'h1C, 0); wr(6'h18, 0);
        line_in = '1; idle(4);
        wr(6'h10, 32'hFF);
        wr(6'h00, 32'hFF);
        wr(6'h20, 32'h8000_0000);
        idle(4);
        wr(6'h10, 32'hFF);
        rd(6'h0C, v); chk("R10 quiet switch", v, 0);
        wr(6'h00, 32'hBF);
        line_in[7] = 1'b0;
        idle(4);
        rd(6'h0C, v); chk("R10 pattern drives", v, 32'h40);
        rd(6'h20, v); chk("R10 test reg", v, 32'h8000_0000);
        idle(2);
        summary();
    end
endmodule